// File: doc/BRIEF.md
# Bi-phase Serial Word Receiver

This block recovers 20-bit-time words from a 1 Mb/s bi-phase (Manchester II) serial bus seen through one transceiver, which presents the line as a complementary pair of receive inputs. Each word opens with a three-bit-time synchronisation waveform whose polarity tells a command/status word from a data word. Sixteen payload bits and one odd-parity bit follow. The receiver hunts for that waveform and times the payload cells from it. It realigns its cell timing on every mid-cell transition and delivers the payload with a one-clock strobe, a word-type flag and an error flag.

The system clock is an integer multiple of the line rate, chosen when the block is built from 12, 16, 20 or 24 MHz. The number of samples per bit cell equals that clock rate in MHz. The error flag merges three causes: a malformed synchronisation waveform, a cell without a mid-cell transition, and a parity mismatch. Message sequencing, command legality, choice between redundant buses and the analog front end belong to other blocks.

Top module: `biphase_word_rx`

## Requirements
- R1: While reset is high and in the first cycle after it falls, word_valid, word_err, word_is_cmd and word_data are all 0.
- R2: The line is high when rx_pos=1 and rx_neg=0, low when rx_pos=0 and rx_neg=1, and idle when the two are equal. A sync of 1.5 bit times high then 1.5 bit times low reports word_is_cmd=1. The inverse sync reports word_is_cmd=0.
- R3: Payload cells follow the sync, first cell into word_data[15] and the last into word_data[0]. A 1 is sent high-then-low and a 0 low-then-high.
- R4: Parity is odd over the 16 payload bits plus the parity cell. A mismatch sets word_err=1, and word_data still carries the received payload.
- R5: A cell whose two halves carry the same level, or whose either half is idle, sets word_err=1.
- R6: If the line at the middle of the second sync half is not the opposite of the first-half level, word_err=1.
- R7: A first sync half is accepted only if its length lies between 1.25 and 1.75 bit times inclusive. Any other run reports no word. An accepted run shifts the strobe by its difference from 1.5 bit times.
- R8: word_valid is high for exactly one clock. For a nominal word it appears after the (20*N+2)-th rising edge, counting as edge 1 the edge that first samples the sync at the inputs (N = samples per bit).
- R9: A mid-cell transition seen inside the middle half of a cell realigns the cell timing. Delaying one transition by d samples delays the strobe by d clocks, and the payload is still decoded.
- R10: word_err and word_is_cmd are 0 whenever word_valid is 0. A clean word reports word_err=0.
- R11: When the inputs have been idle for 22 bit times, no strobe is produced. Words separated by at least two idle bit times are each decoded.
- R12: The samples per bit equal the CLK_MHZ parameter divided by the 1 Mb/s line rate. CLK_MHZ takes the values 12, 16, 20 or 24.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, CLK_MHZ MHz |
| rst | input | 1 | Synchronous active-high reset |
| rx_pos | input | 1 | Positive receive line from the transceiver |
| rx_neg | input | 1 | Negative receive line from the transceiver |
| word_data | output | 16 | Payload of the last word, first cell in bit 15 |
| word_is_cmd | output | 1 | 1 with the strobe for a command/status sync |
| word_valid | output | 1 | One-clock strobe when a word is complete |
| word_err | output | 1 | 1 with the strobe for a sync, coding or parity fault |

## Verification
The strobe and its flags for a word are due 20*N+1 clocks after the first sync sample is driven, where N is the samples per bit. A stretched first sync half moves that point by the stretch, and a delayed mid-cell transition moves it by the delay. The bench records the driving cycle of that first sample and queues each word's due cycle with its expected payload, type and error. At every falling edge it compares the outputs with the head of that queue: a match is required exactly on the due cycle, and on every other cycle the strobe and flags must be low. Malformed syncs queue nothing, so any strobe they cause is reported.

// File: rtl/biphase_pkg.sv
package biphase_pkg;

  localparam int WORD_BITS = 16;

  typedef enum logic [1:0] {
    ST_HUNT  = 2'd0,
    ST_SYNC2 = 2'd1,
    ST_DATA  = 2'd2
  } rx_state_e;

  // act: line is driven (pair differs); val: level when driven (1 = high)
  typedef struct packed {
    logic act;
    logic val;
  } line_t;

endpackage

// File: rtl/biphase_sync.sv
module biphase_sync #(
  parameter int STAGES = 2,
  parameter int LANES  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LANES-1:0] d,
  output logic [LANES-1:0] q
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [STAGES-1:0] pipe;
    always_ff @(posedge clk) begin
      if (rst) pipe <= '0;
      else     pipe <= {pipe[STAGES-2:0], d[g]};
    end
    assign q[g] = pipe[STAGES-1];
  end

endmodule

// File: rtl/biphase_runlen.sv
module biphase_runlen
  import biphase_pkg::*;
#(
  parameter int RUN_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  line_t            ln,
  output line_t            lvl_q,
  output logic [RUN_W-1:0] run_q,
  output logic             edge_seen
);

  // a level change between two driven samples
  assign edge_seen = ln.act && lvl_q.act && (ln.val != lvl_q.val);

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q <= '0;
      run_q <= '0;
    end else begin
      lvl_q <= ln;
      if (ln != lvl_q)
        run_q <= ln.act ? RUN_W'(1) : '0;
      else if (ln.act && (run_q != {RUN_W{1'b1}}))
        run_q <= run_q + 1'b1;
    end
  end

endmodule

// File: rtl/biphase_framer.sv
module biphase_framer
  import biphase_pkg::*;
#(
  parameter int SPB   = 12,
  parameter int RUN_W = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  line_t                ln,
  input  logic                 edge_seen,
  input  logic [RUN_W-1:0]     run_q,
  output logic [WORD_BITS-1:0] word_data,
  output logic                 word_is_cmd,
  output logic                 word_valid,
  output logic                 word_err
);

  localparam int CNT_W     = $clog2(2 * SPB);
  localparam int HALF_SYNC = (3 * SPB) / 2;
  localparam logic [RUN_W-1:0] RUN_LO = RUN_W'(HALF_SYNC - SPB / 4);
  localparam logic [RUN_W-1:0] RUN_HI = RUN_W'(HALF_SYNC + SPB / 4);
  localparam logic [CNT_W-1:0] C_SYNC_MID = CNT_W'((3 * SPB) / 4);
  localparam logic [CNT_W-1:0] C_SYNC_END = CNT_W'(HALF_SYNC - 1);
  localparam logic [CNT_W-1:0] C_Q1       = CNT_W'(SPB / 4);
  localparam logic [CNT_W-1:0] C_Q3       = CNT_W'((3 * SPB) / 4);
  localparam logic [CNT_W-1:0] C_RESYNC   = CNT_W'(SPB / 2 + 1);
  localparam logic [CNT_W-1:0] C_LAST     = CNT_W'(SPB - 1);
  localparam logic [4:0]       LAST_CELL  = 5'(WORD_BITS);

  rx_state_e            st;
  logic [CNT_W-1:0]     cnt;
  logic [4:0]           bitn;
  logic [WORD_BITS-1:0] shreg;
  line_t                h1_q, h2_q;
  logic                 cmd_q, sync_err_q, man_err_q;
  logic                 cell_bad, par_ok, sync_hit;

  assign cell_bad = !h1_q.act || !h2_q.act || (h1_q.val == h2_q.val);
  assign par_ok   = ^{shreg, h1_q.val};
  assign sync_hit = edge_seen && (run_q >= RUN_LO) && (run_q <= RUN_HI);

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_HUNT;
      cnt         <= '0;
      bitn        <= '0;
      shreg       <= '0;
      h1_q        <= '0;
      h2_q        <= '0;
      cmd_q       <= 1'b0;
      sync_err_q  <= 1'b0;
      man_err_q   <= 1'b0;
      word_data   <= '0;
      word_is_cmd <= 1'b0;
      word_valid  <= 1'b0;
      word_err    <= 1'b0;
    end else begin
      word_valid  <= 1'b0;
      word_err    <= 1'b0;
      word_is_cmd <= 1'b0;
      case (st)
        ST_HUNT: begin
          if (sync_hit) begin
            st         <= ST_SYNC2;
            cnt        <= CNT_W'(1);
            cmd_q      <= ~ln.val;       // first-half level was the opposite
            sync_err_q <= 1'b0;
            man_err_q  <= 1'b0;
            bitn       <= '0;
          end
        end
        ST_SYNC2: begin
          if (cnt == C_SYNC_MID && !(ln.act && (ln.val != cmd_q)))
            sync_err_q <= 1'b1;
          if (cnt == C_SYNC_END) begin
            st  <= ST_DATA;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_DATA: begin
          if (cnt == C_Q1) h1_q <= ln;
          if (cnt == C_Q3) h2_q <= ln;
          if (cnt == C_LAST) begin
            cnt <= '0;
            if (bitn == LAST_CELL) begin
              word_valid  <= 1'b1;
              word_data   <= shreg;
              word_is_cmd <= cmd_q;
              word_err    <= sync_err_q | man_err_q | cell_bad | ~par_ok;
              st          <= ST_HUNT;
            end else begin
              shreg     <= {shreg[WORD_BITS-2:0], h1_q.val};
              man_err_q <= man_err_q | cell_bad;
              bitn      <= bitn + 1'b1;
            end
          end else if (edge_seen && (cnt > C_Q1) && (cnt < C_Q3)) begin
            cnt <= C_RESYNC;                 // mid-cell edge realigns timing
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= ST_HUNT;
      endcase
    end
  end

endmodule

// File: rtl/biphase_word_rx.sv
module biphase_word_rx
  import biphase_pkg::*;
#(
  parameter int CLK_MHZ  = 12,
  parameter int LINE_MHZ = 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rx_pos,
  input  logic                 rx_neg,
  output logic [WORD_BITS-1:0] word_data,
  output logic                 word_is_cmd,
  output logic                 word_valid,
  output logic                 word_err
);

  localparam int SPB   = CLK_MHZ / LINE_MHZ;
  localparam int RUN_W = $clog2(4 * SPB);

  logic [1:0]       pair_s;
  line_t            ln, lvl_q;
  logic [RUN_W-1:0] run_q;
  logic             edge_seen;

  biphase_sync #(.STAGES(2), .LANES(2)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({rx_neg, rx_pos}),
    .q   (pair_s)
  );

  assign ln.act = pair_s[0] ^ pair_s[1];
  assign ln.val = pair_s[0];

  biphase_runlen #(.RUN_W(RUN_W)) u_run (
    .clk       (clk),
    .rst       (rst),
    .ln        (ln),
    .lvl_q     (lvl_q),
    .run_q     (run_q),
    .edge_seen (edge_seen)
  );

  biphase_framer #(.SPB(SPB), .RUN_W(RUN_W)) u_framer (
    .clk         (clk),
    .rst         (rst),
    .ln          (ln),
    .edge_seen   (edge_seen),
    .run_q       (run_q),
    .word_data   (word_data),
    .word_is_cmd (word_is_cmd),
    .word_valid  (word_valid),
    .word_err    (word_err)
  );

  logic unused_lvl;
  assign unused_lvl = ^lvl_q;

endmodule

// File: rtl/biphase_word_rx_chk.sv
module biphase_word_rx_chk #(
  parameter int SPB = 12
) (
  input logic clk,
  input logic rst,
  input logic rx_pos,
  input logic rx_neg,
  input logic word_valid,
  input logic word_err,
  input logic word_is_cmd
);

  localparam logic [15:0] MIN_GAP  = 16'(19 * SPB);
  localparam logic [15:0] IDLE_LIM = 16'(22 * SPB);

  logic [15:0] gap_cnt, idle_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_cnt  <= '0;
      idle_cnt <= '0;
    end else begin
      if (word_valid)          gap_cnt <= '0;
      else if (gap_cnt != '1)  gap_cnt <= gap_cnt + 1'b1;
      if (rx_pos != rx_neg)    idle_cnt <= '0;
      else if (idle_cnt != '1) idle_cnt <= idle_cnt + 1'b1;
    end
  end

  assert_single_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    word_valid |=> !word_valid);

  assert_word_spacing_R8: assert property (@(posedge clk) disable iff (rst)
    word_valid |-> (gap_cnt >= MIN_GAP));

  assert_quiet_flags_R10: assert property (@(posedge clk) disable iff (rst)
    !word_valid |-> (!word_err && !word_is_cmd));

  assert_idle_silent_R11: assert property (@(posedge clk) disable iff (rst)
    (idle_cnt >= IDLE_LIM) |-> !word_valid);

endmodule

bind biphase_word_rx biphase_word_rx_chk #(.SPB(CLK_MHZ / LINE_MHZ)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .rx_pos      (rx_pos),
  .rx_neg      (rx_neg),
  .word_valid  (word_valid),
  .word_err    (word_err),
  .word_is_cmd (word_is_cmd)
);

// File: tb/biphase_word_rx_bench.sv
module biphase_word_rx_bench;

  localparam int N = 12;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_pos = 1'b0;
  logic        rx_neg = 1'b0;
  logic [15:0] word_data;
  logic        word_is_cmd, word_valid, word_err;

  biphase_word_rx #(.CLK_MHZ(N), .LINE_MHZ(1)) u_biphase_word_rx (
    .clk (clk), .rst (rst), .rx_pos (rx_pos), .rx_neg (rx_neg),
    .word_data (word_data), .word_is_cmd (word_is_cmd),
    .word_valid (word_valid), .word_err (word_err)
  );

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int errors = 0;

  typedef struct {
    int          at;
    logic [15:0] d;
    logic        c;
    logic        e;
    string       tag;
  } exp_t;
  exp_t q[$];

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  // 1 = high, 0 = low, 2 = idle
  task automatic set_line(input int lv);
    rx_pos = (lv == 1);
    rx_neg = (lv == 0);
  endtask

  task automatic hold(input int lv, input int n);
    repeat (n) begin
      @(negedge clk);
      set_line(lv);
    end
  endtask

  task automatic send_word(input bit cmd, input logic [15:0] d, input int first_len,
                           input bit bad_par, input int kill, input bit bad_sync,
                           input int shift_bit, input int shift, input bit expect_word,
                           input string tag);
    int a;
    int b;
    int p0;
    logic par;
    a = cmd ? 1 : 0;
    b = 1 - a;
    par = ~(^d) ^ bad_par;
    @(negedge clk);
    p0 = cyc + 1;
    if (expect_word)
      q.push_back('{p0 + 20 * N + 1 + shift + (first_len - (3 * N) / 2), d, cmd,
                    bad_par | (kill >= 0) | bad_sync, tag});
    set_line(a);
    hold(a, first_len - 1);
    if (bad_sync) begin
      hold(b, N / 2);
      hold(a, N);
    end else begin
      hold(b, (3 * N) / 2);
    end
    for (int i = 0; i < 17; i++) begin
      int v;
      v = (i < 16) ? int'(d[15 - i]) : int'(par);
      hold(v, N / 2 + ((i == shift_bit) ? shift : 0));
      hold((kill == i) ? v : 1 - v, N / 2);
    end
    hold(2, 3 * N);
  endtask

  // per-clock comparison against the queue of due words
  always @(negedge clk) begin
    if (!rst) begin
      if (q.size() > 0 && cyc == q[0].at) begin
        check(word_valid == 1'b1, "R8", "strobe due (R12 timing)", word_valid, 1);
        check(word_data == q[0].d, "R3", "payload", word_data, q[0].d);
        check(word_is_cmd == q[0].c, "R2", "word type", word_is_cmd, q[0].c);
        check(word_err == q[0].e, q[0].tag, "error flag", word_err, q[0].e);
        void'(q.pop_front());
      end else begin
        check(word_valid == 1'b0, "R8", "no strobe off the due cycle", word_valid, 0);
        check(!word_err && !word_is_cmd, "R10", "flags quiet without strobe",
              {word_err, word_is_cmd}, 0);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    set_line(2);
    repeat (5) @(negedge clk);
    check(word_valid == 0 && word_err == 0 && word_is_cmd == 0 && word_data == 0,
          "R1", "outputs in reset", {word_valid, word_err, word_is_cmd}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(word_valid == 0 && word_data == 0, "R1", "outputs after reset",
          word_data, 0);
    hold(2, 4 * N);

    // clean command and data words (R2, R3, R10)
    send_word(1, 16'hA5C3, 18, 0, -1, 0, -1, 0, 1, "R10");
    send_word(0, 16'h3C96, 18, 0, -1, 0, -1, 0, 1, "R10");
    send_word(1, 16'hFFFF, 18, 0, -1, 0, -1, 0, 1, "R10");
    send_word(0, 16'h0000, 18, 0, -1, 0, -1, 0, 1, "R10");
    // parity mismatch keeps payload (R4)
    send_word(0, 16'h1234, 18, 1, -1, 0, -1, 0, 1, "R4");
    // missing mid-cell transition (R5)
    send_word(1, 16'h5A5A, 18, 0, 5, 0, -1, 0, 1, "R5");
    // malformed second sync half (R6)
    send_word(1, 16'h8001, 18, 0, -1, 1, -1, 0, 1, "R6");
    // sync length boundaries accepted (R7)
    send_word(1, 16'h7E81, 15, 0, -1, 0, -1, 0, 1, "R7");
    send_word(0, 16'hC33C, 21, 0, -1, 0, -1, 0, 1, "R7");
    // sync length just outside the window: no word (R7)
    send_word(1, 16'h0F0F, 22, 0, -1, 0, -1, 0, 0, "R7");
    send_word(1, 16'h0F0F, 14, 0, -1, 0, -1, 0, 0, "R7");
    // delayed mid-cell transition realigns timing (R9)
    send_word(0, 16'hB00B, 18, 0, -1, 0, 8, 2, 1, "R9");
    send_word(1, 16'h6DB6, 18, 0, -1, 0, 3, 2, 1, "R9");
    // long idle: nothing reported (R11)
    hold(2, 25 * N);
    check(word_valid == 0, "R11", "idle line silent", word_valid, 0);
    check(q.size() == 0, "R11", "all due words seen", q.size(), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule